// File: doc/BRIEF.md
# Banked Level-Interrupt Controller

This block gathers level-sensitive interrupt sources into several identical register banks of 32 sources each. A source that is high on a clock edge latches a pending bit. The pending bit stays set until software clears it by writing a one to it. Each pending bit is gated by its own enable bit. The gated vector of a bank is ORed into a single request line for that bank, and the lines go to the CPU's interrupt inputs starting at input 2.

Software reaches every bank through one 32-bit register port. A bank exposes its pending, enable and gated (read-only) vectors. It also exposes a resend register, which lets software raise a pending bit, and a plain mode word. Dispatch is made easier by a per-bank index output. This output names the most significant gated bit, so the handler services the highest-numbered source first.

Top module: `icu_multibank`

## Requirements
- R1: Bank n occupies byte addresses n*0x28 to n*0x28+0x27. Within a bank, offset 0x00 is pending status, 0x08 is enable, 0x10 is the gated vector (status AND enable), 0x18 is resend and 0x20 is mode. Bit i of each register belongs to source i of that bank.
- R2: A source that is high on a clock edge sets its pending bit at that edge. The bit stays set after the source goes low.
- R3: Writing the status offset clears every pending bit whose written data bit is 1. Bits written as 0 are unchanged.
- R4: When a source is high on the same edge as a clear of its bit, the bit stays set.
- R5: Enable resets to all zeros. A source whose enable bit is 0 does not appear in the gated vector, the bank request or the priority index.
- R6: Reading offset 0x10 returns status AND enable. The bank request is high exactly when that vector is non-zero.
- R7: prio_vld[k] is 1 when bank k's gated vector is non-zero. prio_idx[5k+4:5k] is then the position of its most significant set bit. prio_vld[k] is 0 when the gated vector is zero.
- R8: cpu_int[k+2] carries the request of bank k. cpu_int[1:0] are always 0.
- R9: Writing a 1 to a resend bit sets the matching pending bit. The resend offset always reads as 0.
- R10: The mode register is read/write and resets to zero.
- R11: Read data appears on reg_rdata in the cycle after the request edge and holds until the next read. Reads of unmapped addresses return 0, and writes to unmapped addresses change no register.
- R12: After reset, all status, enable and mode registers are zero, cpu_int is zero and prio_vld is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_req | input | 1 | Register access request, one per cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (8) | Byte address |
| reg_wdata | input | SRC_W (32) | Write data |
| reg_rdata | output | SRC_W (32) | Read data, registered |
| src_in | input | NUM_BANKS*SRC_W (160) | Level sources, bank k in bits [32k+31:32k] |
| cpu_int | output | NUM_BANKS+2 (7) | CPU interrupt inputs, bank k on bit k+2 |
| prio_idx | output | NUM_BANKS*5 (25) | Highest gated source index per bank |
| prio_vld | output | NUM_BANKS (5) | Index valid per bank |

## Verification
A source or register write changes state at one clock edge. Because the gated vector, the requests and the priority index are combinational from that state, they are due just after that edge. The bench therefore drives every input on a falling edge and samples the outputs on the following falling edge. A read returns the state from before the request's edge, one cycle later. The read task releases the request on the next falling edge and samples reg_rdata there. The set-versus-clear case holds a source high across the write edge, so that both events fall on the same clock edge.

// File: rtl/icu_pkg.sv
// Shared constants and types of the banked interrupt controller.
// Assumes 32-bit registers laid out at 8-byte spacing inside each bank.
package icu_pkg;
    localparam int unsigned BANK_STRIDE = 40;
    localparam int unsigned OFF_STATUS  = 0;
    localparam int unsigned OFF_ENABLE  = 8;
    localparam int unsigned OFF_MASKED  = 16;
    localparam int unsigned OFF_RESEND  = 24;
    localparam int unsigned OFF_MODE    = 32;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ENABLE,
        SEL_MASKED,
        SEL_RESEND,
        SEL_MODE
    } reg_sel_e;
endpackage

// File: rtl/icu_decode.sv
// Address decoder: finds the bank whose window holds the address and
// the register inside that bank. Assumes banks are contiguous from 0.
module icu_decode
    import icu_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 5,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_BANKS-1:0] bank_hit_o,
    output reg_sel_e             sel_o
);
    int unsigned a_int;
    int unsigned off_v;

    assign a_int = 32'(addr_i);

    // Locate the bank window and the offset within it.
    always_comb begin
        bank_hit_o = '0;
        off_v      = 0;
        for (int unsigned b = 0; b < NUM_BANKS; b++) begin
            if (a_int >= b * BANK_STRIDE && a_int < (b + 1) * BANK_STRIDE) begin
                bank_hit_o[b] = 1'b1;
                off_v         = a_int - b * BANK_STRIDE;
            end
        end
    end

    // Map the in-bank offset to a register select.
    always_comb begin
        case (off_v)
            OFF_STATUS: sel_o = SEL_STATUS;
            OFF_ENABLE: sel_o = SEL_ENABLE;
            OFF_MASKED: sel_o = SEL_MASKED;
            OFF_RESEND: sel_o = SEL_RESEND;
            OFF_MODE:   sel_o = SEL_MODE;
            default:    sel_o = SEL_NONE;
        endcase
        if (bank_hit_o == '0) sel_o = SEL_NONE;
    end
endmodule

// File: rtl/icu_msb_find.sv
// Most-significant-set-bit finder for one bank's gated vector.
// Purely combinational; the index is 0 when no bit is set.
module icu_msb_find #(
    parameter int unsigned W     = 32,
    localparam int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             vld_o
);
    // Scan upward so the highest set bit is the last one kept.
    always_comb begin
        idx_o = '0;
        for (int unsigned i = 0; i < W; i++) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
        vld_o = |vec_i;
    end

    // The chosen bit is set and nothing above it is set.
    always_comb begin
        p_msb_is_top_r7: assert (!vld_o || ((vec_i >> idx_o) == W'(1)));
    end
endmodule

// File: rtl/icu_bank.sv
// One register bank: pending latch, enable mask, resend and mode word,
// gated vector, request line and priority index. Writes arrive as
// pre-decoded strobes; reset is synchronous and active low.
module icu_bank #(
    parameter int unsigned SRC_W = 32,
    localparam int unsigned IDX_W = $clog2(SRC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic             wr_status_i,
    input  logic             wr_enable_i,
    input  logic             wr_resend_i,
    input  logic             wr_mode_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] status_o,
    output logic [SRC_W-1:0] enable_o,
    output logic [SRC_W-1:0] mode_o,
    output logic [SRC_W-1:0] masked_o,
    output logic             irq_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             vld_o
);
    logic [SRC_W-1:0] clr_mask;
    logic [SRC_W-1:0] set_mask;

    // Clear and set vectors; sources and resend both set.
    always_comb begin
        clr_mask = wr_status_i ? wdata_i : '0;
        set_mask = src_i | (wr_resend_i ? wdata_i : '0);
    end

    // Pending latch: set wins over a same-edge clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_mask) | set_mask;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)           enable_o <= '0;
        else if (wr_enable_i) enable_o <= wdata_i;
    end

    // Mode word, stored for software.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_o <= '0;
        else if (wr_mode_i) mode_o <= wdata_i;
    end

    // Gated vector and bank request.
    always_comb begin
        masked_o = status_o & enable_o;
        irq_o    = |masked_o;
    end

    icu_msb_find #(.W(SRC_W)) u_msb (
        .vec_i (masked_o),
        .idx_o (idx_o),
        .vld_o (vld_o)
    );

    p_src_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_i) |=> ((status_o & $past(src_i)) == $past(src_i)));

    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status_i && !wr_resend_i) |=>
        ((status_o & $past(wdata_i) & ~$past(src_i)) == '0));

    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_status_i && !wr_resend_i && src_i == '0) |=> $stable(status_o));

    p_reset_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status_o == '0 && enable_o == '0 && mode_o == '0));

    p_resend_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_resend_i |=> ((status_o & $past(wdata_i)) == $past(wdata_i)));
endmodule

// File: rtl/icu_multibank.sv
// Top of the banked interrupt controller: register port, address
// decode, bank array and read-back register. One access per cycle;
// read data is registered and held until the next read.
module icu_multibank
    import icu_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 5,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned SRC_W     = 32,
    localparam int unsigned IDX_W    = $clog2(SRC_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_req,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [SRC_W-1:0]           reg_wdata,
    output logic [SRC_W-1:0]           reg_rdata,
    input  logic [NUM_BANKS*SRC_W-1:0] src_in,
    output logic [NUM_BANKS+1:0]       cpu_int,
    output logic [NUM_BANKS*IDX_W-1:0] prio_idx,
    output logic [NUM_BANKS-1:0]       prio_vld
);
    logic [NUM_BANKS-1:0] bank_hit;
    reg_sel_e             sel;
    logic                 wr_go;
    logic [NUM_BANKS-1:0] bank_irq;
    logic [SRC_W-1:0]     st_a [NUM_BANKS];
    logic [SRC_W-1:0]     en_a [NUM_BANKS];
    logic [SRC_W-1:0]     md_a [NUM_BANKS];
    logic [SRC_W-1:0]     mk_a [NUM_BANKS];
    logic [SRC_W-1:0]     rd_next;

    assign wr_go = reg_req && reg_wr;

    icu_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_decode (
        .addr_i     (reg_addr),
        .bank_hit_o (bank_hit),
        .sel_o      (sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        icu_bank #(.SRC_W(SRC_W)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .src_i       (src_in[b*SRC_W +: SRC_W]),
            .wr_status_i (wr_go && bank_hit[b] && sel == SEL_STATUS),
            .wr_enable_i (wr_go && bank_hit[b] && sel == SEL_ENABLE),
            .wr_resend_i (wr_go && bank_hit[b] && sel == SEL_RESEND),
            .wr_mode_i   (wr_go && bank_hit[b] && sel == SEL_MODE),
            .wdata_i     (reg_wdata),
            .status_o    (st_a[b]),
            .enable_o    (en_a[b]),
            .mode_o      (md_a[b]),
            .masked_o    (mk_a[b]),
            .irq_o       (bank_irq[b]),
            .idx_o       (prio_idx[b*IDX_W +: IDX_W]),
            .vld_o       (prio_vld[b])
        );
    end

    // Bank requests drive CPU inputs from position 2 upward.
    assign cpu_int = {bank_irq, 2'b00};

    // Read multiplexer; resend and unmapped addresses read as zero.
    always_comb begin
        rd_next = '0;
        for (int unsigned b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                case (sel)
                    SEL_STATUS: rd_next = st_a[b];
                    SEL_ENABLE: rd_next = en_a[b];
                    SEL_MASKED: rd_next = mk_a[b];
                    SEL_MODE:   rd_next = md_a[b];
                    default:    rd_next = '0;
                endcase
            end
        end
    end

    // Read-back register, updated only on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)                 reg_rdata <= '0;
        else if (reg_req && !reg_wr) reg_rdata <= rd_next;
    end

    p_unmapped_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_wr && sel == SEL_NONE) |=> (reg_rdata == '0));

    p_rdata_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && !reg_wr) |=> $stable(reg_rdata));
endmodule

// File: tb/test_icu_multibank.sv
// Directed bench for the banked interrupt controller.
module test_icu_multibank;
    localparam int NB = 5;
    localparam int AW = 8;
    localparam int SW = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_req;
    logic              reg_wr;
    logic [AW-1:0]     reg_addr;
    logic [SW-1:0]     reg_wdata;
    logic [SW-1:0]     reg_rdata;
    logic [NB*SW-1:0]  src_in;
    logic [NB+1:0]     cpu_int;
    logic [NB*5-1:0]   prio_idx;
    logic [NB-1:0]     prio_vld;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    icu_multibank i_icu_multibank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_req   (reg_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_in    (src_in),
        .cpu_int   (cpu_int),
        .prio_idx  (prio_idx),
        .prio_vld  (prio_vld)
    );

    function automatic logic [AW-1:0] ra(int bank, int off);
        return AW'(bank * 40 + off);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_req = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse_src(int bank, logic [31:0] v);
        @(negedge clk);
        src_in[bank*SW +: SW] = v;
        @(negedge clk);
        src_in[bank*SW +: SW] = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R12 cpu_int", 32'(cpu_int), 0);
        chk("R12 prio_vld", 32'(prio_vld), 0);
        rd_reg(ra(0, 0), d);  chk("R12 status b0", d, 0);
        rd_reg(ra(4, 8), d);  chk("R5 enable reset b4", d, 0);
        rd_reg(ra(2, 32), d); chk("R10 mode reset b2", d, 0);
    endtask

    task automatic t_latch_mask();
        logic [31:0] d;
        pulse_src(1, 32'h20);
        rd_reg(ra(1, 0), d);  chk("R2 latched status", d, 32'h20);
        rd_reg(ra(1, 16), d); chk("R5 masked when disabled", d, 0);
        chk("R5 no request when disabled", 32'(cpu_int), 0);
        wr_reg(ra(1, 8), 32'h20);
        chk("R8 cpu_int bit3", 32'(cpu_int), 32'h08);
        chk("R7 idx b1", 32'(prio_idx[5 +: 5]), 5);
        chk("R7 vld b1", 32'(prio_vld), 32'h02);
        rd_reg(ra(1, 16), d); chk("R6 masked read", d, 32'h20);
        wr_reg(ra(1, 0), 32'h0);
        rd_reg(ra(1, 0), d);  chk("R3 zero write keeps", d, 32'h20);
        wr_reg(ra(1, 0), 32'h20);
        rd_reg(ra(1, 0), d);  chk("R3 one write clears", d, 0);
        chk("R6 request drops", 32'(cpu_int), 0);
        wr_reg(ra(1, 8), 32'h0);
    endtask

    task automatic t_priority();
        wr_reg(ra(2, 8), 32'hFFFF_FFFF);
        pulse_src(2, 32'h8000_0008);
        chk("R7 top bit idx", 32'(prio_idx[10 +: 5]), 31);
        chk("R8 cpu_int bit4", 32'(cpu_int), 32'h10);
        wr_reg(ra(2, 0), 32'h8000_0000);
        chk("R7 next bit idx", 32'(prio_idx[10 +: 5]), 3);
        wr_reg(ra(2, 0), 32'h8);
        chk("R7 vld low when empty", 32'(prio_vld), 0);
        pulse_src(2, 32'h1);
        chk("R7 bit0 idx", 32'(prio_idx[10 +: 5]), 0);
        chk("R7 bit0 vld", 32'(prio_vld), 32'h04);
        wr_reg(ra(2, 0), 32'hFFFF_FFFF);
        wr_reg(ra(2, 8), 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        src_in[0 +: SW] = 32'h80;
        wr_reg(ra(0, 0), 32'h80);
        src_in[0 +: SW] = '0;
        rd_reg(ra(0, 0), d); chk("R4 set beats clear", d, 32'h80);
        wr_reg(ra(0, 0), 32'h80);
        rd_reg(ra(0, 0), d); chk("R3 cleared after source low", d, 0);
    endtask

    task automatic t_resend();
        logic [31:0] d;
        wr_reg(ra(3, 24), 32'h1000);
        rd_reg(ra(3, 0), d);  chk("R9 resend sets status", d, 32'h1000);
        rd_reg(ra(3, 24), d); chk("R9 resend reads zero", d, 0);
        wr_reg(ra(3, 8), 32'h1000);
        chk("R8 cpu_int bit5", 32'(cpu_int), 32'h20);
        wr_reg(ra(3, 0), 32'h1000);
        wr_reg(ra(3, 8), 32'h0);
    endtask

    task automatic t_mode_unmapped();
        logic [31:0] d;
        wr_reg(ra(4, 32), 32'hA5A5_0F0F);
        rd_reg(ra(4, 32), d); chk("R10 mode readback", d, 32'hA5A5_0F0F);
        repeat (3) @(negedge clk);
        chk("R11 rdata holds", reg_rdata, 32'hA5A5_0F0F);
        wr_reg(ra(0, 4), 32'hFFFF_FFFF);
        wr_reg(ra(0, 36), 32'hFFFF_FFFF);
        wr_reg(AW'(200), 32'hFFFF_FFFF);
        rd_reg(ra(0, 8), d);  chk("R11 unmapped write, enable b0", d, 0);
        rd_reg(ra(0, 32), d); chk("R11 unmapped write, mode b0", d, 0);
        rd_reg(ra(0, 0), d);  chk("R11 unmapped write, status b0", d, 0);
        rd_reg(AW'(200), d);  chk("R11 unmapped read", d, 0);
    endtask

    task automatic t_stride();
        logic [31:0] d;
        for (int b = 0; b < NB; b++) wr_reg(ra(b, 8), 32'h1111_0000 + 32'(b));
        for (int b = 0; b < NB; b++) begin
            rd_reg(ra(b, 8), d);
            chk("R1 per-bank enable", d, 32'h1111_0000 + 32'(b));
        end
        chk("R6 enables alone raise nothing", 32'(cpu_int), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_req = 1'b0; reg_wr = 1'b0;
        reg_addr = '0; reg_wdata = '0; src_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_mask();
        t_priority();
        t_set_wins();
        t_resend();
        t_mode_unmapped();
        t_stride();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule